// File: doc/BRIEF.md
# Data Tenure Monitor with Byte-Lane Parity

This block watches the data phase of a 64-bit split-transaction processor bus. A start pulse opens a data tenure and carries a transfer type and, for port-size transfers, a beat count. Each cycle in which the transfer acknowledge is high while a tenure is open completes one beat. The block decides from the type and the latched count which acknowledge is the last one. On that acknowledge it pulses an end-of-tenure output.

On every acknowledged read beat, all eight byte lanes are checked against their parity lines, whatever the size of the transfer. Lanes that fail show on a registered per-lane error vector for one cycle. If the parity-enable input is high on that beat, a sticky checkstop flag is set. A start pulse that arrives while a tenure is still open is ignored and sets a sticky protocol-violation flag.

Top module: `data_tenure_monitor`

## Requirements
- R1: Byte lane k covers data_i[8k+7:8k] and parity line par_i[k]. The lane is in error when the nine bits together have even parity, meaning their XOR is 0. The error shows on lane_err_o[k] in the cycle after the acknowledged beat.
- R2: All eight lanes are checked on every acknowledged read beat, for every transfer type.
- R3: Parity is evaluated only in a cycle where ack_i and read_i are both high and a tenure is open. Write beats, idle cycles and cycles with no open tenure give lane_err_o equal to 0.
- R4: checkstop_o is set in the same cycle that lane_err_o shows an error, provided par_en_i was high on that beat. It then stays high until reset.
- R5: A parity error on a beat where par_en_i is low never sets checkstop_o.
- R6: type_i encodes single (0), burst (1) and port-size (2). Code 3 behaves as single. For a single transfer, the first acknowledge ends the tenure. tenure_end_o is high for exactly the one cycle after the final acknowledge.
- R7: A burst tenure ends on its fourth acknowledge. Earlier acknowledges give no end pulse.
- R8: A port-size tenure ends on the acknowledge whose number equals beats_i as latched at start. A latched value of 0 counts as 1.
- R9: An acknowledge while no tenure is open has no effect: no end pulse, no lane error, no beat counted toward a later tenure.
- R10: A start while a tenure is open leaves that tenure and its beat count unchanged. It also sets proto_err_o, which stays high until reset.
- R11: After reset, lane_err_o, tenure_end_o, checkstop_o and proto_err_o are all 0 and no tenure is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a data tenure |
| type_i | input | 2 | Transfer type, sampled with start_i |
| beats_i | input | 4 | Port-size beat count, sampled with start_i |
| data_i | input | 64 | Data bus |
| par_i | input | 8 | Odd parity, one bit per byte lane |
| ack_i | input | 1 | Transfer acknowledge |
| read_i | input | 1 | Read qualifier for the current beat |
| par_en_i | input | 1 | Enables checkstop on parity error |
| lane_err_o | output | 8 | Per-lane parity error, registered |
| tenure_end_o | output | 1 | One-cycle end-of-tenure pulse |
| checkstop_o | output | 1 | Sticky checkstop |
| proto_err_o | output | 1 | Sticky start-while-open flag |

## Verification
Two pairs of events can fall in the same cycle. First, the final acknowledge of a tenure can carry a corrupted parity byte, so the end pulse, the lane error and the rise of checkstop must all appear together. Second, a new start can arrive on the same cycle as a final acknowledge. That start counts as a violation because the tenure is still open at that edge. Directed sequences provoke both cases, and seeded random traffic mixes starts, acknowledges, corrupted lanes and enable settings. Every cycle is judged against a reference model in the bench that tracks open state, beat count and sticky flags from the requirements.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic [1:0] {
    XT_SINGLE = 2'd0,
    XT_BURST  = 2'd1,
    XT_PORT   = 2'd2,
    XT_RSVD   = 2'd3
  } xfer_t;
endpackage

// File: rtl/dtm_parity_check.sv
module dtm_parity_check #(
  parameter int LANES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   par_i,
  output logic [LANES-1:0]   err_now_o,
  output logic [LANES-1:0]   err_q_o
);
  logic [LANES-1:0] bad;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // odd parity expected over 9 bits; XOR of 0 is an error
    assign bad[k] = ~(^{data_i[8*k +: 8], par_i[k]});
  end

  assign err_now_o = sample_i ? bad : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q_o <= '0;
    else         err_q_o <= err_now_o;
  end

  p_idle_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> (err_q_o == '0));
endmodule

// File: rtl/dtm_tenure_ctrl.sv
module dtm_tenure_ctrl
  import dtm_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       type_i,
  input  logic [CNT_W-1:0] beats_i,
  input  logic             ack_i,
  output logic             open_o,
  output logic             end_o,
  output logic             proto_o
);
  localparam logic [CNT_W-1:0] BURST_TGT = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q, tgt_q, tgt_new;
  logic             beat, last;

  always_comb begin
    unique case (xfer_t'(type_i))
      XT_BURST: tgt_new = BURST_TGT;
      XT_PORT:  tgt_new = (beats_i == '0) ? ONE : beats_i;
      default:  tgt_new = ONE;
    endcase
  end

  assign beat = open_q && ack_i;
  assign last = beat && (cnt_q + ONE == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      tgt_q   <= ONE;
      end_o   <= 1'b0;
      proto_o <= 1'b0;
    end else begin
      end_o <= last;
      if (start_i && open_q) proto_o <= 1'b1;
      if (!open_q) begin
        if (start_i) begin
          open_q <= 1'b1;
          cnt_q  <= '0;
          tgt_q  <= tgt_new;
        end
      end else if (last) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else if (beat) begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign open_o = open_q;

  p_end_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (cnt_q < tgt_q));
  p_end_needs_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_o) |-> $past(ack_i));
  p_proto_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_o |=> proto_o);
endmodule

// File: rtl/dtm_checkstop.sv
module dtm_checkstop #(
  parameter int LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LANES-1:0] err_i,
  output logic             cs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cs_o <= 1'b0;
    else if (en_i && |err_i)  cs_o <= 1'b1;
  end

  p_cs_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |=> cs_o);
  p_cs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> $past(en_i));
endmodule

// File: rtl/data_tenure_monitor.sv
module data_tenure_monitor #(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        type_i,
  input  logic [CNT_W-1:0]  beats_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W/8-1:0] par_i,
  input  logic              ack_i,
  input  logic              read_i,
  input  logic              par_en_i,
  output logic [DATA_W/8-1:0] lane_err_o,
  output logic              tenure_end_o,
  output logic              checkstop_o,
  output logic              proto_err_o
);
  localparam int LANES = DATA_W / 8;

  logic             open;
  logic [LANES-1:0] err_now;

  dtm_tenure_ctrl #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .type_i  (type_i),
    .beats_i (beats_i),
    .ack_i   (ack_i),
    .open_o  (open),
    .end_o   (tenure_end_o),
    .proto_o (proto_err_o)
  );

  dtm_parity_check #(.LANES(LANES)) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (open && ack_i && read_i),
    .data_i    (data_i),
    .par_i     (par_i),
    .err_now_o (err_now),
    .err_q_o   (lane_err_o)
  );

  dtm_checkstop #(.LANES(LANES)) u_cs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (par_en_i),
    .err_i  (err_now),
    .cs_o   (checkstop_o)
  );

  p_err_with_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(checkstop_o) |-> (lane_err_o != '0));
endmodule

// File: tb/data_tenure_monitor_bench.sv
module data_tenure_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  xtype = 2'd0;
  logic [3:0]  beats = 4'd0;
  logic [63:0] data = '0;
  logic [7:0]  par = '0;
  logic        ack = 1'b0, rd = 1'b0, pen = 1'b0;
  logic [7:0]  lane_err;
  logic        t_end, cs, perr;

  int checks = 0, failures = 0;

  // reference model state
  bit       m_open;
  int       m_cnt, m_tgt;
  bit       m_cs, m_proto;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_tenure_monitor u_data_tenure_monitor (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .type_i(xtype), .beats_i(beats),
    .data_i(data), .par_i(par), .ack_i(ack), .read_i(rd), .par_en_i(pen),
    .lane_err_o(lane_err), .tenure_end_o(t_end), .checkstop_o(cs), .proto_err_o(perr)
  );

  function automatic logic [7:0] good_par(logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ~^d[8*k +: 8];
    return p;
  endfunction

  function automatic logic [7:0] lane_bad(logic [63:0] d, logic [7:0] p);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) e[k] = ((^d[8*k +: 8]) ^ p[k]) == 1'b0;
    return e;
  endfunction

  function automatic int target_of(logic [1:0] t, logic [3:0] b);
    if (t == 2'd1) return 4;
    if (t == 2'd2) return (b == 0) ? 1 : int'(b);
    return 1;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 0; ack = 0; rd = 0; pen = 0;
    m_open = 0; m_cnt = 0; m_tgt = 1; m_cs = 0; m_proto = 0;
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at negedge, compare after the edge
  task automatic cyc(string tag, bit st, logic [1:0] t, logic [3:0] b,
                     bit a, bit r, logic [63:0] d, logic [7:0] p, bit en);
    logic [7:0] e_err;
    bit e_end;
    @(negedge clk);
    start = st; xtype = t; beats = b; ack = a; rd = r; data = d; par = p; pen = en;
    e_err = (m_open && a && r) ? lane_bad(d, p) : 8'h00;
    e_end = m_open && a && (m_cnt + 1 == m_tgt);
    if (en && e_err != 0) m_cs = 1;
    if (st && m_open) m_proto = 1;
    if (m_open) begin
      if (e_end) begin m_open = 0; m_cnt = 0; end
      else if (a) m_cnt++;
    end else if (st) begin
      m_open = 1; m_cnt = 0; m_tgt = target_of(t, b);
    end
    @(posedge clk); #1;
    check(tag, "lane_err", lane_err, e_err);
    check(tag, "tenure_end", {7'd0, t_end}, {7'd0, e_end});
    check(tag, "checkstop", {7'd0, cs}, {7'd0, m_cs});
    check(tag, "proto_err", {7'd0, perr}, {7'd0, m_proto});
    start = 0; ack = 0;
  endtask

  task automatic ok_beat(string tag, logic [63:0] d, bit r, bit en);
    cyc(tag, 0, 0, 0, 1, r, d, good_par(d), en);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 64'h0, 8'h00, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0bad));
    do_reset();
    @(negedge clk); #1;
    // R11 reset state
    check("R11", "lane_err", lane_err, 8'h00);
    check("R11", "flags", {5'd0, t_end, cs, perr}, 8'h00);

    // R9 ack with nothing open
    ok_beat("R9", 64'h1, 1, 1);
    cyc("R9", 0, 0, 0, 1, 1, 64'h0, 8'h00, 1);
    // R6 single
    cyc("R6", 1, 2'd0, 0, 0, 0, 0, 0, 0);
    ok_beat("R6", 64'hDEAD_BEEF_0123_4567, 1, 1);
    idle("R6");
    // R6 code 3 acts as single
    cyc("R6", 1, 2'd3, 0, 0, 0, 0, 0, 0);
    ok_beat("R6", 64'h55, 1, 0);
    // R7 burst with gap, write beats (R3) and error on final beat with enable low (R5)
    cyc("R7", 1, 2'd1, 0, 0, 0, 0, 0, 0);
    ok_beat("R7", 64'h1111, 0, 1);
    idle("R7");
    cyc("R3", 0, 0, 0, 1, 0, 64'hFF, 8'h00, 1);  // write beat, bad parity ignored
    ok_beat("R7", 64'h2222, 1, 1);
    cyc("R5", 0, 0, 0, 1, 1, 64'h3333, good_par(64'h3333) ^ 8'h81, 0);
    // R8 port-size count 3, with ignored start (R10)
    cyc("R8", 1, 2'd2, 4'd3, 0, 0, 0, 0, 0);
    ok_beat("R8", 64'hA, 1, 0);
    cyc("R10", 1, 2'd0, 0, 0, 0, 0, 0, 0);
    ok_beat("R8", 64'hB, 1, 0);
    ok_beat("R8", 64'hC, 1, 0);
    // R8 count 0 counts as 1
    cyc("R8", 1, 2'd2, 4'd0, 0, 0, 0, 0, 0);
    ok_beat("R8", 64'hD, 1, 0);
    // R1/R2 every lane individually on a narrow single, enable low
    for (int k = 0; k < 8; k++) begin
      cyc("R2", 1, 2'd0, 0, 0, 0, 0, 0, 0);
      cyc("R1", 0, 0, 0, 1, 1, 64'h0123_4567_89AB_CDEF,
          good_par(64'h0123_4567_89AB_CDEF) ^ (8'h01 << k), 0);
    end
    // R4 coincident: final burst ack with parity error, enabled, plus start on same cycle
    cyc("R4", 1, 2'd1, 0, 0, 0, 0, 0, 0);
    ok_beat("R4", 64'h1, 1, 0);
    ok_beat("R4", 64'h2, 1, 0);
    ok_beat("R4", 64'h3, 1, 0);
    cyc("R4", 1, 2'd0, 0, 1, 1, 64'h4, good_par(64'h4) ^ 8'h10, 1);
    idle("R4");
    ok_beat("R9", 64'h5, 1, 0);

    // random traffic
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [63:0] d;
      logic [7:0]  p;
      d = {$urandom, $urandom};
      p = good_par(d);
      if ($urandom_range(0, 7) == 0) p ^= 8'($urandom);
      cyc("R3", $urandom_range(0, 5) == 0, 2'($urandom), 4'($urandom_range(0, 5)),
          $urandom_range(0, 2) != 0, $urandom_range(0, 3) != 0, d, p,
          $urandom_range(0, 9) == 0);
      if (i == 300) do_reset();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule